// File: doc/BRIEF.md
# SPI Configuration-Port Command Responder

This block is the command front end of a configuration port, reached over a SPI mode 0 link. The host lowers chip select and sends an 8-bit opcode followed by three operand bytes. Read-type commands treat those three bytes as filler and return their data on the bytes that follow them. The data is an identification code, a 32-bit status word, or a one-byte busy indicator. Control commands change the status word. These commands turn the interface on and off, start an erase or a refresh that keeps the block busy for a fixed number of clocks, and rewind the payload write address.

A burst command turns every later byte of the same chip-select window into a payload strobe. Each strobe carries the data byte and its write address. The SPI pins are sampled by the system clock through two-flop synchronisers. The SPI clock must therefore be several times slower than the system clock.

Top module: `cfgport_cmd_responder`

## Requirements
- R1: A command takes effect only when its 32nd bit (opcode plus three operand bytes) has been received. If chip select rises earlier, the partial command is discarded and changes no state.
- R2: Opcode 0xE0 returns the `ID_CODE` parameter on response bytes 4 to 7, most significant byte first. MISO is 0 during bytes 1 to 3.
- R3: Opcode 0x3C returns the status word on bytes 4 to 7, most significant byte first. The fields are: bit 8 done, bit 9 interface enabled, bit 12 busy, bit 13 fail, bit 28 invalid command. All other bits are 0, and every bit is 0 after reset.
- R4: Opcode 0xC6 sets the interface-enabled bit. Opcode 0x26 clears it.
- R5: Opcode 0xF0 returns one byte on byte 4. The byte is 0x01 while an erase or refresh is counting and 0x00 when idle.
- R6: Opcode 0x0E with first operand byte 0x01 sets busy for `ERASE_CYCLES` system clocks. When the window ends, the fail bit is cleared. Opcode 0x0E with any other first operand byte has no effect.
- R7: Opcode 0x79 sets busy for `REFRESH_CYCLES` clocks and clears the done and invalid-command bits.
- R8: An erase or refresh issued while busy is dropped and sets the fail bit.
- R9: After opcode 0x7A and three operand bytes, each further byte produces a one-clock `burst_valid` pulse with the byte and the current write address. The address increments per byte and continues across bursts. This goes on until chip select rises.
- R10: Opcode 0x46 resets the write address to zero.
- R11: Any opcode not listed in R2 to R10 sets the invalid-command bit. A 0xFF opcode (no operation) and the read opcodes do not set it.
- R12: Opcode 0x26 sets the done bit if at least one burst byte arrived since the previous 0x26.
- R13: MISO is 0 while chip select is high and outside response data. The outputs are idle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI clock, mode 0 |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data from host |
| miso | output | 1 | SPI data to host |
| burst_valid | output | 1 | One-clock strobe per burst payload byte |
| burst_data | output | 8 | Payload byte |
| burst_addr | output | ADDR_W | Write address of the payload byte |

## Verification
The bench attacks four points:
- **Aborted command.** A command cut short by chip select must leave the status untouched. A design that acted on the opcode byte would show the enable bit set.
- **Response alignment.** Reads must not leak data into the three filler bytes and must be most-significant byte first. A design off by one byte would return a shifted identification code.
- **Busy overlap.** An erase issued during a refresh must raise fail without restarting the window. A design that accepted it would stay busy longer and keep fail clear.
- **Burst addressing.** The scoreboard checks that addresses continue across two bursts and restart after a rewind. It also checks that header bytes never produce a strobe.

// File: rtl/cfgport_cmd_responder.sv
module cfgport_cmd_responder #(
  parameter logic [31:0] ID_CODE        = 32'hA5C3_0F17,
  parameter int          ERASE_CYCLES   = 64,
  parameter int          REFRESH_CYCLES = 48,
  parameter int          ADDR_W         = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  output logic              burst_valid,
  output logic [7:0]        burst_data,
  output logic [ADDR_W-1:0] burst_addr
);

  localparam int BUSY_MAX = (ERASE_CYCLES > REFRESH_CYCLES) ? ERASE_CYCLES : REFRESH_CYCLES;
  localparam int CNT_W    = $clog2(BUSY_MAX + 1);

  localparam logic [7:0] OP_ID      = 8'hE0;
  localparam logic [7:0] OP_STAT    = 8'h3C;
  localparam logic [7:0] OP_EN      = 8'hC6;
  localparam logic [7:0] OP_DIS     = 8'h26;
  localparam logic [7:0] OP_POLL    = 8'hF0;
  localparam logic [7:0] OP_ERASE   = 8'h0E;
  localparam logic [7:0] OP_REFRESH = 8'h79;
  localparam logic [7:0] OP_ADDR0   = 8'h46;
  localparam logic [7:0] OP_BURST   = 8'h7A;
  localparam logic [7:0] OP_NOP     = 8'hFF;

  logic [2:0] sclk_q;
  logic [1:0] cs_q, mosi_q;
  logic       cs_s, mosi_s, s_rise, s_fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= 2'b11;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      cs_q   <= {cs_q[0], cs_n};
      mosi_q <= {mosi_q[0], mosi};
    end

  assign cs_s   = cs_q[1];
  assign mosi_s = mosi_q[1];
  assign s_rise = sclk_q[1] & ~sclk_q[2];
  assign s_fall = ~sclk_q[1] & sclk_q[2];

  logic [2:0] bit_cnt;
  logic [3:0] byte_idx;
  logic [6:0] rx_sr;
  logic [7:0] rx_byte, opcode, op1, tx_sr, rsp_byte;
  logic [31:0] rsp_word;
  logic       rx_done, exec;

  assign rx_byte = {rx_sr, mosi_s};
  assign rx_done = s_rise & ~cs_s & (bit_cnt == 3'd7);
  assign exec    = rx_done & (byte_idx == 4'd3);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt  <= '0;
      byte_idx <= '0;
      rx_sr    <= '0;
      opcode   <= '0;
      op1      <= '0;
    end else if (cs_s) begin
      bit_cnt  <= '0;
      byte_idx <= '0;
    end else if (s_rise) begin
      rx_sr   <= rx_byte[6:0];
      bit_cnt <= bit_cnt + 3'd1;
      if (bit_cnt == 3'd7) begin
        if (byte_idx != 4'd8) byte_idx <= byte_idx + 4'd1;
        if (byte_idx == 4'd0) opcode <= rx_byte;
        if (byte_idx == 4'd1) op1 <= rx_byte;
      end
    end

  always_comb
    case (byte_idx)
      4'd4:    rsp_byte = rsp_word[31:24];
      4'd5:    rsp_byte = rsp_word[23:16];
      4'd6:    rsp_byte = rsp_word[15:8];
      4'd7:    rsp_byte = rsp_word[7:0];
      default: rsp_byte = 8'h00;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 tx_sr <= '0;
    else if (cs_s)              tx_sr <= '0;
    else if (s_fall)            tx_sr <= (bit_cnt == 3'd0) ? rsp_byte : {tx_sr[6:0], 1'b0};

  assign miso = tx_sr[7];

  logic [CNT_W-1:0] busy_cnt;
  logic             busy_erase, st_done, st_en, st_fail, st_inv, burst_seen, busy;
  logic [31:0]      status;

  assign busy   = (busy_cnt != '0);
  assign status = {3'b0, st_inv, 14'b0, st_fail, busy, 2'b0, st_en, st_done, 8'b0};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    rsp_word <= '0;
    else if (exec)
      case (opcode)
        OP_ID:   rsp_word <= ID_CODE;
        OP_STAT: rsp_word <= status;
        OP_POLL: rsp_word <= {7'b0, busy, 24'b0};
        default: rsp_word <= '0;
      endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy_cnt   <= '0;
      busy_erase <= 1'b0;
      st_done    <= 1'b0;
      st_en      <= 1'b0;
      st_fail    <= 1'b0;
      st_inv     <= 1'b0;
      burst_seen <= 1'b0;
    end else begin
      if (busy) begin
        busy_cnt <= busy_cnt - CNT_W'(1);
        if (busy_cnt == CNT_W'(1) && busy_erase) st_fail <= 1'b0;
      end
      if (burst_valid) burst_seen <= 1'b1;
      if (exec)
        case (opcode)
          OP_EN:  st_en <= 1'b1;
          OP_DIS: begin
            st_en      <= 1'b0;
            burst_seen <= 1'b0;
            if (burst_seen) st_done <= 1'b1;
          end
          OP_ERASE:
            if (op1 == 8'h01) begin
              if (busy) st_fail <= 1'b1;
              else begin
                busy_cnt   <= CNT_W'(ERASE_CYCLES);
                busy_erase <= 1'b1;
              end
            end
          OP_REFRESH:
            if (busy) st_fail <= 1'b1;
            else begin
              busy_cnt   <= CNT_W'(REFRESH_CYCLES);
              busy_erase <= 1'b0;
              st_done    <= 1'b0;
              st_inv     <= 1'b0;
            end
          OP_ID, OP_STAT, OP_POLL, OP_ADDR0, OP_BURST, OP_NOP: ;
          default: st_inv <= 1'b1;
        endcase
    end

  logic [ADDR_W-1:0] waddr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      waddr       <= '0;
      burst_valid <= 1'b0;
      burst_data  <= '0;
      burst_addr  <= '0;
    end else begin
      burst_valid <= 1'b0;
      if (exec && opcode == OP_ADDR0) waddr <= '0;
      if (rx_done && byte_idx >= 4'd4 && opcode == OP_BURST) begin
        burst_valid <= 1'b1;
        burst_data  <= rx_byte;
        burst_addr  <= waddr;
        waddr       <= waddr + ADDR_W'(1);
      end
    end

  p_busy_countdown_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_cnt != '0) |=> (busy_cnt == $past(busy_cnt) - CNT_W'(1)));

  p_inv_clears_on_refresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_inv) |-> $past(exec && opcode == OP_REFRESH));

  p_done_rises_on_disable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_done) |-> $past(exec && opcode == OP_DIS));

  p_burst_addr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid |=> (waddr == $past(burst_addr) + ADDR_W'(1)));

  p_idle_when_deselected_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (byte_idx == 4'd0 && !miso));

endmodule

// File: tb/test_cfgport_cmd_responder.sv
module test_cfgport_cmd_responder;
  localparam logic [31:0] ID = 32'h1E2D_3C4B;
  localparam int HALF = 8;
  localparam int AW = 16;

  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, mosi = 0;
  logic miso, burst_valid;
  logic [7:0] burst_data;
  logic [AW-1:0] burst_addr;
  int errors = 0, checks = 0;
  logic [AW+7:0] exp_q[$];

  always #5 clk = ~clk;

  cfgport_cmd_responder #(.ID_CODE(ID), .ERASE_CYCLES(800), .REFRESH_CYCLES(3000), .ADDR_W(AW))
    i_cfgport_cmd_responder (.clk, .rst_n, .sclk, .cs_n, .mosi, .miso, .burst_valid, .burst_data, .burst_addr);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n && burst_valid) begin
      if (exp_q.size() == 0) chk("R9 unexpected strobe", {8'h0, burst_addr, burst_data}, 32'hFFFF_FFFF);
      else chk("R9/R10 burst item", {8'h0, burst_addr, burst_data}, {8'h0, exp_q.pop_front()});
    end

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbyte(input logic [7:0] t, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      mosi = t[i];
      waitc(HALF);
      r[i] = miso;
      sclk = 1;
      waitc(HALF);
      sclk = 0;
    end
  endtask

  task automatic cs_lo(); cs_n = 0; waitc(HALF); endtask
  task automatic cs_hi(); waitc(HALF); cs_n = 1; waitc(2*HALF); endtask

  task automatic cmd(input logic [7:0] op, input logic [7:0] b1);
    logic [7:0] r;
    cs_lo();
    sbyte(op, r); sbyte(b1, r); sbyte(8'h00, r); sbyte(8'h00, r);
    cs_hi();
  endtask

  task automatic rd32(input logic [7:0] op, output logic [31:0] v, output logic [23:0] dummy);
    logic [7:0] r;
    cs_lo();
    sbyte(op, r);
    for (int k = 0; k < 3; k++) begin sbyte(8'h00, r); dummy[23-8*k -: 8] = r; end
    for (int k = 0; k < 4; k++) begin sbyte(8'h00, r); v[31-8*k -: 8] = r; end
    cs_hi();
  endtask

  task automatic stat(output logic [31:0] v);
    logic [23:0] d;
    rd32(8'h3C, v, d);
  endtask

  task automatic poll(output logic [7:0] v);
    logic [7:0] r;
    cs_lo();
    sbyte(8'hF0, r); sbyte(0, r); sbyte(0, r); sbyte(0, r);
    sbyte(0, v);
    cs_hi();
  endtask

  task automatic burst(input int n, input logic [AW-1:0] a0, input logic [7:0] seed);
    logic [7:0] r;
    cs_lo();
    sbyte(8'h7A, r); sbyte(0, r); sbyte(0, r); sbyte(0, r);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back({a0 + AW'(k), seed + 8'(k * 37)});
      sbyte(seed + 8'(k * 37), r);
    end
    cs_hi();
  endtask

  task automatic wait_idle();
    logic [7:0] b;
    for (int k = 0; k < 20; k++) begin
      poll(b);
      if (b == 8'h00) break;
    end
  endtask

  initial begin
    waitc(150000);
    chk("watchdog", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [23:0] d;
    logic [7:0] b, r;
    waitc(4);
    rst_n = 1;
    waitc(4);
    chk("R13 reset miso", {31'b0, miso}, 0);
    chk("R13 reset strobe", {31'b0, burst_valid}, 0);

    rd32(8'hE0, v, d);
    chk("R2 id code", v, ID);
    chk("R2 filler bytes", {8'h0, d}, 0);
    stat(v);
    chk("R3 reset status", v, 0);

    cs_lo(); sbyte(8'hC6, r); sbyte(8'h00, r); cs_hi();
    stat(v);
    chk("R1 aborted command", v, 0);

    cmd(8'hC6, 0);
    stat(v);
    chk("R4 enable set", v, 32'h0000_0200);
    cmd(8'h55, 0);
    stat(v);
    chk("R11 invalid opcode", v, 32'h1000_0200);
    cmd(8'hFF, 8'hFF);
    stat(v);
    chk("R11 nop no effect", v, 32'h1000_0200);

    cmd(8'h79, 0);
    stat(v);
    chk("R7 refresh busy, invalid cleared", v, 32'h0000_1200);
    cmd(8'h0E, 8'h01);
    poll(b);
    chk("R5 poll busy", {24'h0, b}, 32'h01);
    stat(v);
    chk("R8 erase while busy fails", v, 32'h0000_3200);
    wait_idle();
    poll(b);
    chk("R5 poll idle", {24'h0, b}, 0);
    stat(v);
    chk("R8 fail held after refresh", v, 32'h0000_2200);

    cmd(8'h0E, 8'h02);
    poll(b);
    chk("R6 wrong operand ignored", {24'h0, b}, 0);
    cmd(8'h0E, 8'h01);
    poll(b);
    chk("R6 erase busy", {24'h0, b}, 32'h01);
    waitc(1000);
    poll(b);
    chk("R6 erase window ended", {24'h0, b}, 0);
    stat(v);
    chk("R6 fail cleared", v, 32'h0000_0200);

    cmd(8'h46, 0);
    burst(5, 0, 8'h11);
    burst(2, 5, 8'hA0);
    cmd(8'h46, 0);
    burst(1, 0, 8'h5A);
    waitc(4);
    chk("R9 all burst items seen", exp_q.size(), 0);

    cmd(8'h26, 0);
    stat(v);
    chk("R12 done after burst, R4 disabled", v, 32'h0000_0100);
    cmd(8'h79, 0);
    wait_idle();
    stat(v);
    chk("R7 refresh clears done", v, 0);
    cmd(8'h26, 0);
    stat(v);
    chk("R12 no burst no done", v, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule